// File: doc/BRIEF.md
# Optimistic Transaction Commit Timestamp Validator

This block checks optimistic transactions against a small on-chip table of tuples and then either commits or aborts them. Each table row holds a data word and two logical timestamps: the write stamp, set when the row was last written, and the read stamp, the last logical time up to which the stored version is known to be valid. A transaction arrives as a list of entries on a valid/ready stream. A read entry carries the row index and the two stamps seen when the row was read. A write entry carries the row index and the new data.

When `start` is pulsed, the engine derives the commit timestamp from the stamps themselves. No central counter hands out timestamps. The engine then walks the list three times, one entry per clock: first to form the timestamp, then to confirm that every read can be moved forward to that time, and, only if all reads can, to apply the writes and the read-stamp extensions. A one-cycle `dn_valid` pulse reports the verdict and the timestamp. A read-only transaction may commit at a logical time earlier than that of a writer that finished before it.

A host port reads any row combinationally and writes rows while the engine is idle. It is used to load and inspect the table.

Top module: `tcv_validator`

## Requirements
- R1: `ld_ready` is high only when the engine is idle, holds fewer than DEPTH entries and `start` is low. An entry is stored on a clock edge where `ld_valid` and `ld_ready` are both high. Up to DEPTH entries are held. The buffer is empty again after each decision.
- R2: The commit timestamp is the largest of two sets of values: (current read stamp + 1) for each write entry's row, and the observed write stamp of each read entry. With no entries it is 0.
- R3: A read entry whose observed read stamp is below the commit timestamp passes only if the row's current write stamp still equals the observed write stamp. A read entry whose observed read stamp is at or above the commit timestamp passes whatever the row now holds. Any failing read aborts the transaction.
- R4: On commit, every row named by a write entry holds the new data, with write stamp = read stamp = commit timestamp.
- R5: On commit, a read entry whose observed read stamp is below the commit timestamp raises the row's read stamp to the larger of its current value and the commit timestamp. The row's data and write stamp are kept.
- R6: On abort, no row of the table changes.
- R7: `dn_valid` is a single-cycle pulse. During that pulse, `dn_commit` gives the verdict (1 = commit) and `dn_cts` gives the timestamp, and `dn_cts` is also given on abort. Counting the clock edge that samples `start` as edge 1, the pulse follows edge 3N+1 on commit and edge 2N+1 on abort, where N is the number of loaded entries.
- R8: The host port returns the addressed row at any time. A host write lands on the next edge only while the engine is idle and has no effect otherwise.
- R9: After reset every row is zero, the entry buffer is empty, `dn_valid` is low and `ld_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Entry offered on the set-loading stream |
| ld_ready | output | 1 | Entry will be accepted this cycle |
| ld_write | input | 1 | 1 = write entry, 0 = read entry |
| ld_id | input | $clog2(NTUP) | Row index |
| ld_wts | input | TS_W | Observed write stamp (read entries) |
| ld_rts | input | TS_W | Observed read stamp (read entries) |
| ld_data | input | DATA_W | New data (write entries) |
| start | input | 1 | Begin validation of the loaded entries |
| dn_valid | output | 1 | Decision pulse |
| dn_commit | output | 1 | 1 = committed, 0 = aborted |
| dn_cts | output | TS_W | Commit timestamp |
| hst_we | input | 1 | Host row write |
| hst_addr | input | $clog2(NTUP) | Host row index |
| hst_wdata | input | DATA_W | Host write data |
| hst_wwts | input | TS_W | Host write stamp value |
| hst_wrts | input | TS_W | Host read stamp value |
| hst_rdata | output | DATA_W | Addressed row data |
| hst_rwts | output | TS_W | Addressed row write stamp |
| hst_rrts | output | TS_W | Addressed row read stamp |

## Verification
The assertions assume that no stamp in the table or in a loaded entry comes near the top of its range, so that read stamp + 1 never wraps. They also assume the host only writes rows whose read stamp is at least their write stamp. The stimulus keeps every stamp below 40 and loads every row with its read stamp three above its write stamp. `ld_valid` is never held while the buffer is full, and the host write issued during validation is there only to show that it is dropped.

// File: rtl/tv_pkg.sv
package tv_pkg;
  localparam int TS_W   = 16;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [TS_W-1:0]   wts;
    logic [TS_W-1:0]   rts;
  } tuple_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CTS,
    S_CHK,
    S_APPLY,
    S_DONE
  } phase_e;
endpackage

// File: rtl/tv_set_buf.sv
module tv_set_buf #(
  parameter int DEPTH = 8,
  parameter int ENT_W = 53,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ENT_W-1:0] push_ent,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_ent,
  output logic [CNT_W-1:0] cnt
);
  logic [ENT_W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && cnt == CNT_W'(g)) slot[g] <= push_ent;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (push)     cnt <= cnt + CNT_W'(1);
  end

  assign rd_ent = slot[rd_idx];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt < CNT_W'(DEPTH)); // R1
endmodule

// File: rtl/tv_tuple_table.sv
module tv_tuple_table
  import tv_pkg::*;
#(
  parameter int NTUP = 16,
  localparam int ID_W = $clog2(NTUP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [ID_W-1:0] waddr,
  input  tuple_t          wrow,
  input  logic [ID_W-1:0] raddr_a,
  output tuple_t          rrow_a,
  input  logic [ID_W-1:0] raddr_b,
  output tuple_t          rrow_b
);
  tuple_t row [NTUP];

  for (genvar g = 0; g < NTUP; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)                        row[g] <= '0;
      else if (we && waddr == ID_W'(g))  row[g] <= wrow;
    end
  end

  assign rrow_a = row[raddr_a];
  assign rrow_b = row[raddr_b];
endmodule

// File: rtl/tcv_validator.sv
module tcv_validator
  import tv_pkg::*;
#(
  parameter int NTUP  = 16,
  parameter int DEPTH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_valid,
  output logic                    ld_ready,
  input  logic                    ld_write,
  input  logic [$clog2(NTUP)-1:0] ld_id,
  input  logic [TS_W-1:0]         ld_wts,
  input  logic [TS_W-1:0]         ld_rts,
  input  logic [DATA_W-1:0]       ld_data,
  input  logic                    start,
  output logic                    dn_valid,
  output logic                    dn_commit,
  output logic [TS_W-1:0]         dn_cts,
  input  logic                    hst_we,
  input  logic [$clog2(NTUP)-1:0] hst_addr,
  input  logic [DATA_W-1:0]       hst_wdata,
  input  logic [TS_W-1:0]         hst_wwts,
  input  logic [TS_W-1:0]         hst_wrts,
  output logic [DATA_W-1:0]       hst_rdata,
  output logic [TS_W-1:0]         hst_rwts,
  output logic [TS_W-1:0]         hst_rrts
);
  localparam int ID_W  = $clog2(NTUP);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = 1 + ID_W + 2 * TS_W + DATA_W;

  phase_e           state;
  logic [IDX_W-1:0] idx;
  logic [TS_W-1:0]  cts;
  logic             bad;
  logic [CNT_W-1:0] cnt;
  logic [ENT_W-1:0] cur_flat;
  logic             push, clr, last;

  logic              cur_wr;
  logic [ID_W-1:0]   cur_id;
  logic [TS_W-1:0]   cur_wts, cur_rts;
  logic [DATA_W-1:0] cur_data;
  tuple_t            trow, hrow, tw_row;
  logic              tw_en;
  logic [ID_W-1:0]   tw_addr;
  logic [TS_W-1:0]   cand;
  logic              fail;

  assign ld_ready = (state == S_IDLE) && (cnt < CNT_W'(DEPTH)) && !start;
  assign push     = ld_valid && ld_ready;
  assign clr      = (state == S_DONE);

  tv_set_buf #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_set (
    .clk, .rst_n, .push,
    .push_ent({ld_write, ld_id, ld_wts, ld_rts, ld_data}),
    .clr, .rd_idx(idx), .rd_ent(cur_flat), .cnt
  );

  assign {cur_wr, cur_id, cur_wts, cur_rts, cur_data} = cur_flat;

  tv_tuple_table #(.NTUP(NTUP)) u_tbl (
    .clk, .rst_n, .we(tw_en), .waddr(tw_addr), .wrow(tw_row),
    .raddr_a(cur_id), .rrow_a(trow),
    .raddr_b(hst_addr), .rrow_b(hrow)
  );

  assign hst_rdata = hrow.data;
  assign hst_rwts  = hrow.wts;
  assign hst_rrts  = hrow.rts;

  // Timestamp floor contributed by the current entry, and the lease check.
  assign cand = cur_wr ? trow.rts + TS_W'(1) : cur_wts;
  assign fail = !cur_wr && (cts > cur_rts) && (trow.wts != cur_wts);
  assign last = (CNT_W'(idx) + CNT_W'(1)) == cnt;

  // Single table write port: host while idle, engine during the apply pass.
  always_comb begin
    tw_en   = 1'b0;
    tw_addr = cur_id;
    tw_row  = trow;
    if (state == S_IDLE) begin
      tw_en   = hst_we;
      tw_addr = hst_addr;
      tw_row  = '{data: hst_wdata, wts: hst_wwts, rts: hst_wrts};
    end else if (state == S_APPLY) begin
      if (cur_wr) begin
        tw_en  = 1'b1;
        tw_row = '{data: cur_data, wts: cts, rts: cts};
      end else if (cts > cur_rts) begin
        tw_en      = 1'b1;
        tw_row.rts = (trow.rts > cts) ? trow.rts : cts;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      cts       <= '0;
      bad       <= 1'b0;
      dn_commit <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          idx <= '0;
          cts <= '0;
          bad <= 1'b0;
          if (cnt == '0) begin
            dn_commit <= 1'b1;
            state     <= S_DONE;
          end else begin
            state <= S_CTS;
          end
        end
        S_CTS: begin
          if (cand > cts) cts <= cand;
          idx <= last ? '0 : idx + IDX_W'(1);
          if (last) state <= S_CHK;
        end
        S_CHK: begin
          if (fail) bad <= 1'b1;
          idx <= last ? '0 : idx + IDX_W'(1);
          if (last) begin
            if (bad || fail) begin
              dn_commit <= 1'b0;
              state     <= S_DONE;
            end else begin
              state <= S_APPLY;
            end
          end
        end
        S_APPLY: begin
          idx <= last ? '0 : idx + IDX_W'(1);
          if (last) begin
            dn_commit <= 1'b1;
            state     <= S_DONE;
          end
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign dn_valid = (state == S_DONE);
  assign dn_cts   = cts;

  AST_WR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHK && cur_wr) |-> cts > trow.rts); // R2
  AST_RD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHK && !cur_wr) |-> cts >= cur_wts); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |=> !dn_valid); // R7
  AST_ABORT_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_commit) |-> $past(state) == S_CHK); // R6
  AST_ENGINE_WRITE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_en && state != S_IDLE) |-> (state == S_APPLY && tw_row.rts >= tw_row.wts)); // R4
  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> state == S_IDLE); // R1
endmodule

// File: tb/tcv_validator_tb.sv
`timescale 1ns/1ps
module tcv_validator_tb;
  localparam int NTUP  = 16;
  localparam int DEPTH = 8;
  localparam int NV    = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0, ld_write = 1'b0;
  logic        ld_ready;
  logic [3:0]  ld_id = '0;
  logic [15:0] ld_wts = '0, ld_rts = '0, ld_data = '0;
  logic        start = 1'b0;
  logic        dn_valid, dn_commit;
  logic [15:0] dn_cts;
  logic        hst_we = 1'b0;
  logic [3:0]  hst_addr = '0;
  logic [15:0] hst_wdata = '0, hst_wwts = '0, hst_wrts = '0;
  logic [15:0] hst_rdata, hst_rwts, hst_rrts;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  tcv_validator #(.NTUP(NTUP), .DEPTH(DEPTH)) u_dut (
    .clk, .rst_n, .ld_valid, .ld_ready, .ld_write, .ld_id, .ld_wts, .ld_rts,
    .ld_data, .start, .dn_valid, .dn_commit, .dn_cts, .hst_we, .hst_addr,
    .hst_wdata, .hst_wwts, .hst_wrts, .hst_rdata, .hst_rwts, .hst_rrts
  );

  typedef struct packed {
    logic [1:0]  n;
    logic        w0; logic [3:0] id0; logic [15:0] ow0; logic [15:0] or0;
    logic        w1; logic [3:0] id1; logic [15:0] ow1; logic [15:0] or1;
    logic        commit;
    logic [15:0] cts;
  } vec_t;

  // Table preloaded before each vector: row i = data 0x100+i, wts i, rts i+3.
  localparam vec_t VEC [NV] = '{
    '{2'd2, 1'b0, 4'd2, 16'd2, 16'd5,  1'b0, 4'd5, 16'd5, 16'd8,  1'b1, 16'd5},  // read-only
    '{2'd2, 1'b0, 4'd1, 16'd1, 16'd4,  1'b1, 4'd3, 16'd0, 16'd0,  1'b1, 16'd7},  // ext + write
    '{2'd2, 1'b0, 4'd4, 16'd1, 16'd6,  1'b1, 4'd0, 16'd0, 16'd0,  1'b1, 16'd4},  // stale, no ext
    '{2'd2, 1'b0, 4'd6, 16'd2, 16'd3,  1'b1, 4'd7, 16'd0, 16'd0,  1'b0, 16'd11}, // abort
    '{2'd1, 1'b1, 4'd15, 16'd0, 16'd0, 1'b0, 4'd0, 16'd0, 16'd0,  1'b1, 16'd19}, // write only
    '{2'd2, 1'b0, 4'd9, 16'd9, 16'd12, 1'b1, 4'd9, 16'd0, 16'd0,  1'b1, 16'd13}  // same row r+w
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic preload();
    for (int i = 0; i < NTUP; i++) begin
      @(negedge clk);
      hst_we = 1'b1; hst_addr = 4'(i);
      hst_wdata = 16'h100 + 16'(i); hst_wwts = 16'(i); hst_wrts = 16'(i + 3);
    end
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic push(input bit w, input logic [3:0] id, input logic [15:0] ow,
                      input logic [15:0] orr);
    @(negedge clk);
    ld_valid = 1'b1; ld_write = w; ld_id = id; ld_wts = ow; ld_rts = orr;
    ld_data = 16'hA000 + 16'(id);
  endtask

  task automatic run(output int lat, input bit inject);
    int cyc;
    @(negedge clk);
    ld_valid = 1'b0;
    start = 1'b1;
    #1;
    check(ld_ready == 1'b0, "R1", "ld_ready with start high", ld_ready, 0);
    cyc = 0;
    do begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = 1'b0;
      if (inject && cyc == 2) begin
        hst_we = 1'b1; hst_addr = 4'd12;
        hst_wdata = 16'hDEAD; hst_wwts = 16'd30; hst_wrts = 16'd31;
      end else begin
        hst_we = 1'b0;
      end
    end while (!dn_valid && cyc < 200);
    hst_we = 1'b0;
    lat = cyc;
  endtask

  task automatic check_row(input logic [3:0] id, input logic [15:0] ed,
                           input logic [15:0] ew, input logic [15:0] er,
                           input string req);
    hst_addr = id;
    #1;
    check(hst_rdata == ed, req, $sformatf("row %0d data", id), hst_rdata, ed);
    check(hst_rwts == ew, req, $sformatf("row %0d wts", id), hst_rwts, ew);
    check(hst_rrts == er, req, $sformatf("row %0d rts", id), hst_rrts, er);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin : main
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(dn_valid == 1'b0, "R9", "dn_valid after reset", dn_valid, 0);
    check(ld_ready == 1'b1, "R9", "ld_ready after reset", ld_ready, 1);
    check_row(4'd5, 16'd0, 16'd0, 16'd0, "R9");

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [3:0] ids [2];
      logic       ws [2];
      logic [15:0] ors [2];
      t = VEC[v];
      ids[0] = t.id0; ids[1] = t.id1; ws[0] = t.w0; ws[1] = t.w1;
      ors[0] = t.or0; ors[1] = t.or1;
      preload();
      push(t.w0, t.id0, t.ow0, t.or0);
      if (t.n == 2'd2) push(t.w1, t.id1, t.ow1, t.or1);
      run(lat, 1'b0);
      check(dn_valid == 1'b1, "R7", $sformatf("v%0d dn_valid", v), dn_valid, 1);
      check(dn_commit == t.commit, t.commit ? "R3" : "R3",
            $sformatf("v%0d verdict", v), dn_commit, t.commit);
      check(dn_cts == t.cts, "R2", $sformatf("v%0d cts", v), dn_cts, t.cts);
      check(lat == (t.commit ? 3 * int'(t.n) + 1 : 2 * int'(t.n) + 1), "R7",
            $sformatf("v%0d latency", v), lat,
            t.commit ? 3 * int'(t.n) + 1 : 2 * int'(t.n) + 1);
      @(negedge clk);
      check(dn_valid == 1'b0, "R7", $sformatf("v%0d pulse width", v), dn_valid, 0);
      for (int e = 0; e < int'(t.n); e++) begin
        logic [15:0] ed, ew, er;
        logic wr_any;
        string rq;
        wr_any = 1'b0;
        for (int k = 0; k < int'(t.n); k++) if (ws[k] && ids[k] == ids[e]) wr_any = 1'b1;
        ed = 16'h100 + 16'(ids[e]); ew = 16'(ids[e]); er = 16'(ids[e]) + 16'd3;
        rq = "R6";
        if (t.commit) begin
          if (wr_any) begin
            ed = 16'hA000 + 16'(ids[e]); ew = t.cts; er = t.cts; rq = "R4";
          end else if (t.cts > ors[e]) begin
            er = (er > t.cts) ? er : t.cts; rq = "R5";
          end else rq = "R5";
        end
        check_row(ids[e], ed, ew, er, rq);
      end
    end

    // R2/R7: empty transaction commits at 0 one edge after start
    run(lat, 1'b0);
    check(dn_commit == 1'b1, "R2", "empty verdict", dn_commit, 1);
    check(dn_cts == 16'd0, "R2", "empty cts", dn_cts, 0);
    check(lat == 1, "R7", "empty latency", lat, 1);

    // R1/R8: full buffer, host write ignored while busy
    preload();
    check_row(4'd3, 16'h103, 16'd3, 16'd6, "R8");
    for (int i = 0; i < DEPTH; i++) push(1'b0, 4'(i), 16'(i), 16'(i + 3));
    @(negedge clk);
    ld_valid = 1'b0;
    #1;
    check(ld_ready == 1'b0, "R1", "ld_ready when full", ld_ready, 0);
    run(lat, 1'b1);
    check(dn_commit == 1'b1, "R3", "full verdict", dn_commit, 1);
    check(dn_cts == 16'd7, "R2", "full cts", dn_cts, 7);
    check(lat == 3 * DEPTH + 1, "R7", "full latency", lat, 3 * DEPTH + 1);
    @(negedge clk);
    check(ld_ready == 1'b1, "R1", "ld_ready after decision", ld_ready, 1);
    check_row(4'd12, 16'h10C, 16'd12, 16'd15, "R8");
    check_row(4'd0, 16'h100, 16'd0, 16'd7, "R5");
    check_row(4'd6, 16'h106, 16'd6, 16'd9, "R5");

    report();
    $finish;
  end
endmodule